// File: doc/BRIEF.md
# Shift-and-Add Set-Bit Counter

This block is a small hardwired processor that counts the set bits of a data word. A controller waits in an idle state for a start request. On the cycle that start is seen, it copies the input word into a working register and clears a running count. It then scans the word one bit per clock. Each step adds the working register's least significant bit to the count and shifts the register right by one place, both on the same edge. Two status flags go from the datapath back to the controller: the bit under test and a non-zero indication.

The scan stops as soon as the working register is zero. The time taken therefore depends on the position of the highest set bit, not on the word width. An all-zero word ends after a single check. On completion, the count is copied into an output register and a one-cycle done pulse is raised. The output register keeps its value until the next completion. The controller is input-based: the zero test decides in the scan state whether to step or to finish. Only an idle state and a scan state are needed.

Top module: `bitcount_fsmd`

## Requirements
- R1: While reset is high and on the first cycle after it, `done` is 0 and `result` is 0. A run cut short by reset produces no `done` pulse.
- R2: When `start` is 1 in the idle state, `data_in` is captured on that clock edge. Later changes of `data_in` have no effect on the result of that run.
- R3: The reported `result` equals the number of 1 bits in the captured word, for any word from all zeros to all ones.
- R4: Let h be the bit index of the highest set bit plus one (0 for a zero word). Count the edge that captured the word as edge 0. `done` and the new `result` appear after edge h+1.
- R5: An all-zero word gives `result` 0 and `done` after edge 1, with no shift steps.
- R6: `done` is high for exactly one clock cycle per completed run.
- R7: `result` changes only on the edge that raises `done`, and otherwise holds its last value.
- R8: `start` is ignored while a scan is in progress. It changes neither that run's result nor its latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a count; sampled only when idle |
| data_in | input | DW | Word to be counted |
| result | output | $clog2(DW+1) | Registered set-bit count of the last run |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
Each result is due after a number of edges fixed by the highest set bit of the word: it appears after edge h+1, counting the capturing edge as 0. The bench drives all inputs on falling edges. After raising `start` it counts falling edges until `done` is seen, and compares that count with h+2. It reads `result` on the same falling edge, then confirms on later falling edges that `done` has dropped and `result` holds. Words with a low, middle and top highest bit are chosen so that both short and full-width latencies are checked against this rule.

// File: rtl/popc_pkg.sv
package popc_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } popc_state_t;
endpackage

// File: rtl/popc_datapath.sv
module popc_datapath #(
  parameter int DW = 16,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_word,
  input  logic          do_step,
  input  logic          do_emit,
  input  logic [DW-1:0] word_in,
  output logic          word_nz,
  output logic          word_lsb,
  output logic [CW-1:0] count_out
);
  logic [DW-1:0] work_r;
  logic [CW-1:0] tally_r;
  logic [CW-1:0] out_r;

  // status toward the controller
  assign word_nz  = |work_r;
  assign word_lsb = work_r[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      work_r  <= '0;
      tally_r <= '0;
    end else if (ld_word) begin
      work_r  <= word_in;
      tally_r <= '0;
    end else if (do_step) begin
      work_r  <= work_r >> 1;
      tally_r <= tally_r + CW'(word_lsb);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_r <= '0;
    end else if (do_emit) begin
      out_r <= tally_r;
    end
  end

  assign count_out = out_r;
endmodule

// File: rtl/popc_ctrl.sv
module popc_ctrl
  import popc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic word_nz,
  output logic ld_word,
  output logic do_step,
  output logic do_emit,
  output logic scanning,
  output logic fin_pulse
);
  popc_state_t st_r;
  logic        fin_r;

  // input-based decisions: each depends on state and status together
  always_comb begin
    ld_word = (st_r == ST_IDLE) && go;
    do_step = (st_r == ST_SCAN) && word_nz;
    do_emit = (st_r == ST_SCAN) && !word_nz;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_r  <= ST_IDLE;
      fin_r <= 1'b0;
    end else begin
      fin_r <= do_emit;
      unique case (st_r)
        ST_IDLE: if (go)       st_r <= ST_SCAN;
        ST_SCAN: if (!word_nz) st_r <= ST_IDLE;
        default:               st_r <= ST_IDLE;
      endcase
    end
  end

  assign scanning  = (st_r == ST_SCAN);
  assign fin_pulse = fin_r;
endmodule

// File: rtl/bitcount_fsmd.sv
module bitcount_fsmd #(
  parameter int DW = 16,
  localparam int CW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] data_in,
  output logic [CW-1:0] result,
  output logic          done
);
  logic ld_word, do_step, do_emit, word_nz, word_lsb, scanning;

  popc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .go        (start),
    .word_nz   (word_nz),
    .ld_word   (ld_word),
    .do_step   (do_step),
    .do_emit   (do_emit),
    .scanning  (scanning),
    .fin_pulse (done)
  );

  popc_datapath #(.DW(DW)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ld_word   (ld_word),
    .do_step   (do_step),
    .do_emit   (do_emit),
    .word_in   (data_in),
    .word_nz   (word_nz),
    .word_lsb  (word_lsb),
    .count_out (result)
  );
endmodule

// File: rtl/bitcount_fsmd_chk.sv
module bitcount_fsmd_chk #(
  parameter int DW = 16,
  localparam int CW = $clog2(DW + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [CW-1:0] result,
  input logic          done,
  input logic          scanning,
  input logic          word_nz
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  assert_result_range_R3: assert property (@(posedge clk) disable iff (rst)
    result <= CW'(DW));

  assert_start_enters_scan_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(start) && !$past(scanning)) |-> scanning);

  assert_done_after_scan_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(scanning) && !scanning));

  assert_scan_continues_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(scanning) && $past(word_nz)) |-> (scanning && !done));
endmodule

bind bitcount_fsmd bitcount_fsmd_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .result   (result),
  .done     (done),
  .scanning (scanning),
  .word_nz  (word_nz)
);

// File: tb/bitcount_fsmd_tb_top.sv
`timescale 1ns/1ps
module bitcount_fsmd_tb_top;
  localparam int DW = 16;
  localparam int CW = $clog2(DW + 1);
  localparam int NV = 8;

  // word, expected count, highest set bit index plus one
  localparam logic [DW-1:0] V_WORD [NV] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF,
                                            16'h00F0, 16'h1234, 16'hA5A5, 16'h0100};
  localparam int V_CNT [NV] = '{0, 1, 1, 16, 4, 5, 8, 1};
  localparam int V_TOP [NV] = '{0, 1, 16, 16, 8, 13, 16, 9};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic [CW-1:0] result;
  logic          done;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bitcount_fsmd #(.DW(DW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .data_in(data_in),
    .result(result), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts a run on a falling edge and waits for done; optionally pokes start mid-run.
  task automatic run_word(input logic [DW-1:0] w, input int exp_cnt, input int top,
                          input bit poke);
    int seen;
    seen = -1;
    data_in = w;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    data_in = ~w;            // R2: later input changes must not matter
    for (int k = 1; k <= DW + 8; k++) begin
      if (poke && k == 4) begin
        start   = 1'b1;      // R8: ignored while scanning
        data_in = 16'h00FF;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (done && seen < 0) seen = k + 1;
      if (seen >= 0) break;
    end
    start = 1'b0;
    check(seen == top + 2, "R4 latency", seen, top + 2);
    check(int'(result) == exp_cnt, "R3 count", int'(result), exp_cnt);
    @(negedge clk);
    check(done == 1'b0, "R6 single pulse", int'(done), 0);
    @(negedge clk);
    @(negedge clk);
    check(int'(result) == exp_cnt, "R7 hold", int'(result), exp_cnt);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(result == '0, "R1 result in reset", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && result == '0, "R1 after reset", int'(result), 0);

    for (int i = 0; i < NV; i++) begin
      run_word(V_WORD[i], V_CNT[i], V_TOP[i], 1'b0);
    end

    // R5: zero word finishes after edge 1 with count 0
    run_word(16'h0000, 0, 0, 1'b0);

    // R8: a start during a long scan is ignored
    run_word(16'h8000, 1, 16, 1'b1);
    run_word(16'h0003, 2, 2, 1'b1);

    // R1: reset mid-run clears state and no done follows
    data_in = 16'hFFFF;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(result == '0, "R1 result after mid-run reset", int'(result), 0);
    begin
      int pulses;
      pulses = 0;
      for (int k = 0; k < DW + 4; k++) begin
        @(negedge clk);
        if (done) pulses++;
      end
      check(pulses == 0, "R1 no done after aborted run", pulses, 0);
    end

    // recovery after reset
    run_word(16'h7001, 4, 15, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule